// File: doc/BRIEF.md
# Dual-clock width-converting FIFO

This block is a first-in first-out queue between two unrelated clock domains. The write port and the read port have different data widths, related by a power of two from 1:8 to 8:1, and 1:1 is allowed. When the write word is wider, each stored word is handed out as several narrow read words. When the read word is wider, several narrow writes are gathered into one read word. Storage is a plain inferred two-port array of wide words.

Each side sees only its own signals. The write side has a full flag, an almost-full flag, a fill level counted in write words, and a one-cycle accept strobe and reject strobe. The read side has an empty flag, an almost-empty flag, a level counted in read words, and a one-cycle data-valid strobe and reject strobe. Every pointer moves in narrow-word units. Between the domains a pointer travels only in whole wide-word steps, as a Gray code through a two-stage synchronizer. This makes both flags cautious: they may clear late, but they never allow an overrun or an underrun.

Top module: `xwf_fifo`

## Requirements
- R1: While the write reset is low, the full flag is high and no write is accepted. After both resets, full=0, almost-full=0, empty=1, almost-empty=1, and both levels read 0.
- R2: With the write port RATIO times wider than the read port, each written word comes out as RATIO consecutive read words, taken from its most significant slice down to its least.
- R3: With the read port RATIO times wider than the write port, the first narrow word of each group lands in the most significant slice of the read word, and later narrow words fill the lower slices in order.
- R4: A write presented while full is discarded. The overflow strobe pulses one write-clock cycle later, no accept strobe is given, the write level does not change, and the stored data is left untouched.
- R5: A read presented while empty returns no data. The underflow strobe pulses one read-clock cycle later, the valid strobe stays low, and the read level does not change.
- R6: An accepted write raises the accept strobe for the next write-clock cycle. An accepted read raises the valid strobe for the next read-clock cycle, with the data on the read data bus in that same cycle.
- R7: The write level is the space in use, in write words rounded up. It follows a write on the next write-clock cycle. Full is high exactly when the level equals the depth in write words. Almost-full is high when the level is at least that depth minus one.
- R8: The read level is the data available, in whole read words rounded down. Empty is high exactly when this level is 0. Almost-empty is high when it is 1 or less.
- R9: The opposite side's pointer is seen only in whole wide-word steps and after synchronizer delay. Flags may therefore lag, for example full stays high until the reader has drained a complete wide word. The occupancy seen on either side never exceeds the depth and never goes below zero.
- R10: With write and read clocks of unrelated periods, the order of the data is kept exactly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Write-domain clock |
| wr_rst_n | input | 1 | Write-domain reset, asynchronous, active low |
| wr_en | input | 1 | Write request |
| wr_data | input | WR_W | Write word |
| wr_full | output | 1 | No room for a write word |
| wr_almost_full | output | 1 | Room for at most one write word |
| wr_level | output | WCNT | Space in use, in write words |
| wr_ack | output | 1 | Previous write was stored |
| wr_overflow | output | 1 | Previous write was rejected |
| rd_clk | input | 1 | Read-domain clock |
| rd_rst_n | input | 1 | Read-domain reset, asynchronous, active low |
| rd_en | input | 1 | Read request |
| rd_data | output | RD_W | Read word, valid while rd_valid is high |
| rd_empty | output | 1 | No read word available |
| rd_almost_empty | output | 1 | At most one read word available |
| rd_level | output | RCNT | Read words available |
| rd_valid | output | 1 | rd_data holds the word from the previous read |
| rd_underflow | output | 1 | Previous read was rejected |

## Verification
The in-design properties assume that both resets are asserted together, so that both pointer sets start from zero at the same time. They also assume that every request input is stable around its own clock edge. The occupancy bounds and the one-bit Gray change rely on this. The stimulus asserts both resets from time zero, releases them on the same write-clock falling edge, and drives every request and data input only on the falling edge of its own clock. The two clocks run at 10 ns and 13 ns periods, so the synchronizers see changing phase throughout the run.

// File: rtl/xwf_pkg.sv
package xwf_pkg;

   localparam int XWF_MAX_RATIO = 8;
   localparam int XWF_SYNC_STAGES = 2;

   function automatic logic [31:0] to_gray(input logic [31:0] b);
      return b ^ (b >> 1);
   endfunction

   function automatic logic [31:0] from_gray(input logic [31:0] g);
      logic [31:0] b;
      b[31] = g[31];
      for (int i = 30; i >= 0; i--) begin
         b[i] = b[i+1] ^ g[i];
      end
      return b;
   endfunction

endpackage

// File: rtl/xwf_sync.sv
module xwf_sync #(
   parameter int W      = 4,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);

   logic [W-1:0] stg [STAGES];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < STAGES; i++) stg[i] <= '0;
      end else begin
         stg[0] <= d;
         for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
      end
   end

   assign q = stg[STAGES-1];

   if (STAGES < 2) begin : g_bad_stages
      $error("xwf_sync: at least two stages are required");
   end

endmodule

// File: rtl/xwf_mem.sv
module xwf_mem #(
   parameter int WR_W  = 32,
   parameter int RD_W  = 8,
   parameter int WORDS = 16,
   parameter int AWN   = 6
) (
   input  logic            wclk,
   input  logic            we,
   input  logic [AWN-1:0]  waddr,
   input  logic [WR_W-1:0] wdata,
   input  logic            rclk,
   input  logic            rrst_n,
   input  logic            re,
   input  logic [AWN-1:0]  raddr,
   output logic [RD_W-1:0] rdata
);

   localparam int WIDE   = (WR_W > RD_W) ? WR_W : RD_W;
   localparam int NARROW = (WR_W > RD_W) ? RD_W : WR_W;
   localparam int RATIO  = WIDE / NARROW;
   localparam int RB     = $clog2(RATIO);
   localparam int IDXW   = $clog2(WORDS);

   logic [WIDE-1:0] mem [WORDS];

   // write port: whole wide word, or one narrow slice (first slice = MSB end)
   if (WR_W >= RD_W) begin : g_wr_whole
      always_ff @(posedge wclk) begin
         if (we) mem[waddr[AWN-1 -: IDXW]] <= wdata;
      end
      if (RB > 0) begin : g_wsel_unused
         logic unused_wsel;
         assign unused_wsel = ^waddr[RB-1:0];
      end
   end else begin : g_wr_slice
      logic [IDXW-1:0] widx;
      logic [RB-1:0]   wsel;
      assign widx = waddr[AWN-1 -: IDXW];
      assign wsel = waddr[RB-1:0];
      always_ff @(posedge wclk) begin
         if (we) mem[widx][(RATIO-1-int'(wsel))*NARROW +: NARROW] <= wdata;
      end
   end

   // read port: registered, whole wide word or one narrow slice
   if (RD_W >= WR_W) begin : g_rd_whole
      always_ff @(posedge rclk or negedge rrst_n) begin
         if (!rrst_n)  rdata <= '0;
         else if (re)  rdata <= mem[raddr[AWN-1 -: IDXW]];
      end
      if (RB > 0) begin : g_rsel_unused
         logic unused_rsel;
         assign unused_rsel = ^raddr[RB-1:0];
      end
   end else begin : g_rd_slice
      logic [IDXW-1:0] ridx;
      logic [RB-1:0]   rsel;
      assign ridx = raddr[AWN-1 -: IDXW];
      assign rsel = raddr[RB-1:0];
      always_ff @(posedge rclk or negedge rrst_n) begin
         if (!rrst_n) rdata <= '0;
         else if (re) rdata <= mem[ridx][(RATIO-1-int'(rsel))*NARROW +: NARROW];
      end
   end

endmodule

// File: rtl/xwf_wr_ctrl.sv
module xwf_wr_ctrl import xwf_pkg::*; #(
   parameter int PW   = 7,
   parameter int RB   = 2,
   parameter int SH   = 2,
   parameter int CNTW = 5
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             en,
   input  logic [PW-RB-1:0] far_gray,
   output logic [PW-2:0]    addr,
   output logic             take,
   output logic [PW-RB-1:0] gray_q,
   output logic             full,
   output logic             afull,
   output logic [CNTW-1:0]  count,
   output logic             ack,
   output logic             ovf
);

   localparam int STEP    = 1 << SH;
   localparam int DEPTH_N = 1 << (PW-1);
   localparam int DEPTH_S = DEPTH_N >> SH;

   logic [PW-1:0] ptr, ptr_nx, far, used, rounded;

   assign far     = PW'(from_gray(32'(far_gray))) << RB;
   assign used    = ptr - far;
   assign rounded = (used + PW'(STEP-1)) >> SH;
   assign count   = CNTW'(rounded);
   assign full    = !rst_n || (count == CNTW'(DEPTH_S));
   assign afull   = !rst_n || (count >= CNTW'(DEPTH_S-1));
   assign take    = en && !full;
   assign ptr_nx  = take ? ptr + PW'(STEP) : ptr;
   assign addr    = ptr[PW-2:0];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ptr    <= '0;
         gray_q <= '0;
         ack    <= 1'b0;
         ovf    <= 1'b0;
      end else begin
         ptr    <= ptr_nx;
         gray_q <= (PW-RB)'(to_gray(32'(ptr_nx >> RB)));
         ack    <= take;
         ovf    <= en && full;
      end
   end

   assert_no_overrun_R9: assert property (@(posedge clk) disable iff (!rst_n)
      used <= PW'(DEPTH_N));

   assert_gray_step_R9: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(gray_q ^ $past(gray_q)) <= 1);

   assert_full_holds_ptr_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (en && full) |=> $stable(ptr));

   assert_ack_has_request_R6: assert property (@(posedge clk) disable iff (!rst_n)
      ack |-> $past(en));

endmodule

// File: rtl/xwf_rd_ctrl.sv
module xwf_rd_ctrl import xwf_pkg::*; #(
   parameter int PW   = 7,
   parameter int RB   = 2,
   parameter int SH   = 0,
   parameter int CNTW = 7
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             en,
   input  logic [PW-RB-1:0] far_gray,
   output logic [PW-2:0]    addr,
   output logic             take,
   output logic [PW-RB-1:0] gray_q,
   output logic             empty,
   output logic             aempty,
   output logic [CNTW-1:0]  count,
   output logic             valid,
   output logic             udf
);

   localparam int STEP    = 1 << SH;
   localparam int DEPTH_N = 1 << (PW-1);

   logic [PW-1:0] ptr, ptr_nx, far, used;

   assign far    = PW'(from_gray(32'(far_gray))) << RB;
   assign used   = far - ptr;
   assign count  = CNTW'(used >> SH);
   assign empty  = (count == '0);
   assign aempty = (count <= CNTW'(1));
   assign take   = en && !empty;
   assign ptr_nx = take ? ptr + PW'(STEP) : ptr;
   assign addr   = ptr[PW-2:0];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ptr    <= '0;
         gray_q <= '0;
         valid  <= 1'b0;
         udf    <= 1'b0;
      end else begin
         ptr    <= ptr_nx;
         gray_q <= (PW-RB)'(to_gray(32'(ptr_nx >> RB)));
         valid  <= take;
         udf    <= en && empty;
      end
   end

   assert_no_underrun_R9: assert property (@(posedge clk) disable iff (!rst_n)
      used <= PW'(DEPTH_N));

   assert_rgray_step_R9: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(gray_q ^ $past(gray_q)) <= 1);

   assert_empty_holds_ptr_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (en && empty) |=> $stable(ptr));

   assert_valid_has_request_R6: assert property (@(posedge clk) disable iff (!rst_n)
      valid |-> $past(en));

endmodule

// File: rtl/xwf_fifo.sv
module xwf_fifo import xwf_pkg::*; #(
   parameter  int WR_W      = 32,
   parameter  int RD_W      = 8,
   parameter  int MEM_WORDS = 16,
   localparam int WIDE      = (WR_W > RD_W) ? WR_W : RD_W,
   localparam int NARROW    = (WR_W > RD_W) ? RD_W : WR_W,
   localparam int RATIO     = WIDE / NARROW,
   localparam int RB        = $clog2(RATIO),
   localparam int AWN       = $clog2(MEM_WORDS) + RB,
   localparam int PW        = AWN + 1,
   localparam int DEPTH_N   = MEM_WORDS * RATIO,
   localparam int WSH       = (WR_W > RD_W) ? RB : 0,
   localparam int RSH       = (RD_W > WR_W) ? RB : 0,
   localparam int WCNT      = $clog2(DEPTH_N >> WSH) + 1,
   localparam int RCNT      = $clog2(DEPTH_N >> RSH) + 1
) (
   input  logic            wr_clk,
   input  logic            wr_rst_n,
   input  logic            wr_en,
   input  logic [WR_W-1:0] wr_data,
   output logic            wr_full,
   output logic            wr_almost_full,
   output logic [WCNT-1:0] wr_level,
   output logic            wr_ack,
   output logic            wr_overflow,
   input  logic            rd_clk,
   input  logic            rd_rst_n,
   input  logic            rd_en,
   output logic [RD_W-1:0] rd_data,
   output logic            rd_empty,
   output logic            rd_almost_empty,
   output logic [RCNT-1:0] rd_level,
   output logic            rd_valid,
   output logic            rd_underflow
);

   localparam int CGW = PW - RB;

   if (RATIO > XWF_MAX_RATIO || (1 << RB) != RATIO || WIDE != NARROW * RATIO) begin : g_bad_ratio
      $error("xwf_fifo: port widths must differ by a power of two no larger than 8");
   end
   if (MEM_WORDS < 2 || (1 << $clog2(MEM_WORDS)) != MEM_WORDS) begin : g_bad_depth
      $error("xwf_fifo: MEM_WORDS must be a power of two of at least 2");
   end

   logic [AWN-1:0] waddr, raddr;
   logic           wtake, rtake;
   logic [CGW-1:0] wgray, rgray, wgray_in_rd, rgray_in_wr;

   xwf_wr_ctrl #(.PW(PW), .RB(RB), .SH(WSH), .CNTW(WCNT)) u_wr (
      .clk(wr_clk), .rst_n(wr_rst_n), .en(wr_en), .far_gray(rgray_in_wr),
      .addr(waddr), .take(wtake), .gray_q(wgray), .full(wr_full),
      .afull(wr_almost_full), .count(wr_level), .ack(wr_ack), .ovf(wr_overflow)
   );

   xwf_rd_ctrl #(.PW(PW), .RB(RB), .SH(RSH), .CNTW(RCNT)) u_rd (
      .clk(rd_clk), .rst_n(rd_rst_n), .en(rd_en), .far_gray(wgray_in_rd),
      .addr(raddr), .take(rtake), .gray_q(rgray), .empty(rd_empty),
      .aempty(rd_almost_empty), .count(rd_level), .valid(rd_valid), .udf(rd_underflow)
   );

   xwf_sync #(.W(CGW), .STAGES(XWF_SYNC_STAGES)) u_w2r (
      .clk(rd_clk), .rst_n(rd_rst_n), .d(wgray), .q(wgray_in_rd)
   );

   xwf_sync #(.W(CGW), .STAGES(XWF_SYNC_STAGES)) u_r2w (
      .clk(wr_clk), .rst_n(wr_rst_n), .d(rgray), .q(rgray_in_wr)
   );

   xwf_mem #(.WR_W(WR_W), .RD_W(RD_W), .WORDS(MEM_WORDS), .AWN(AWN)) u_mem (
      .wclk(wr_clk), .we(wtake), .waddr(waddr), .wdata(wr_data),
      .rclk(rd_clk), .rrst_n(rd_rst_n), .re(rtake), .raddr(raddr), .rdata(rd_data)
   );

   assert_full_in_reset_R1: assert property (@(posedge wr_clk)
      !wr_rst_n |-> (wr_full && !wr_ack));

endmodule

// File: tb/sim_xwf_fifo.sv
module sim_xwf_fifo;

   logic wclk = 1'b0;
   logic rclk = 1'b0;
   always #5   wclk = ~wclk;
   always #6.5 rclk = ~rclk;

   logic wrst_n, rrst_n;

   // u0: 32-bit write, 8-bit read, 16 wide words
   logic        a_wen, a_full, a_afull, a_ack, a_ovf;
   logic [31:0] a_wdata;
   logic [4:0]  a_wlvl;
   logic        a_ren, a_empty, a_aempty, a_valid, a_udf;
   logic [7:0]  a_rdata;
   logic [6:0]  a_rlvl;

   // u1: 8-bit write, 32-bit read, 4 wide words
   logic        b_wen, b_full, b_afull, b_ack, b_ovf;
   logic [7:0]  b_wdata;
   logic [4:0]  b_wlvl;
   logic        b_ren, b_empty, b_aempty, b_valid, b_udf;
   logic [31:0] b_rdata;
   logic [2:0]  b_rlvl;

   xwf_fifo #(.WR_W(32), .RD_W(8), .MEM_WORDS(16)) u0 (
      .wr_clk(wclk), .wr_rst_n(wrst_n), .wr_en(a_wen), .wr_data(a_wdata),
      .wr_full(a_full), .wr_almost_full(a_afull), .wr_level(a_wlvl),
      .wr_ack(a_ack), .wr_overflow(a_ovf),
      .rd_clk(rclk), .rd_rst_n(rrst_n), .rd_en(a_ren), .rd_data(a_rdata),
      .rd_empty(a_empty), .rd_almost_empty(a_aempty), .rd_level(a_rlvl),
      .rd_valid(a_valid), .rd_underflow(a_udf)
   );

   xwf_fifo #(.WR_W(8), .RD_W(32), .MEM_WORDS(4)) u1 (
      .wr_clk(wclk), .wr_rst_n(wrst_n), .wr_en(b_wen), .wr_data(b_wdata),
      .wr_full(b_full), .wr_almost_full(b_afull), .wr_level(b_wlvl),
      .wr_ack(b_ack), .wr_overflow(b_ovf),
      .rd_clk(rclk), .rd_rst_n(rrst_n), .rd_en(b_ren), .rd_data(b_rdata),
      .rd_empty(b_empty), .rd_almost_empty(b_aempty), .rd_level(b_rlvl),
      .rd_valid(b_valid), .rd_underflow(b_udf)
   );

   localparam logic [31:0] VEC [8] = '{
      32'h01234567, 32'h89ABCDEF, 32'hDEADBEEF, 32'h00000000,
      32'hFFFFFFFF, 32'hA5A55A5A, 32'h80000001, 32'h13579BDF
   };

   int n_run  = 0;
   int n_fail = 0;
   bit done   = 1'b0;

   task automatic chk(input string req, input string what,
                      input logic [63:0] act, input logic [63:0] exp);
      n_run++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   function automatic logic [7:0] slice_of(input logic [31:0] w, input int k);
      return w[8*(3-k) +: 8];
   endfunction

   function automatic logic [31:0] fill_word(input int i);
      return 32'hA0000000 + 32'(i) * 32'h01020304;
   endfunction

   task automatic a_write(input logic [31:0] d);
      @(negedge wclk); a_wen = 1'b1; a_wdata = d;
      @(negedge wclk); a_wen = 1'b0;
   endtask

   task automatic a_read();
      @(negedge rclk); a_ren = 1'b1;
      @(negedge rclk); a_ren = 1'b0;
   endtask

   task automatic b_write(input logic [7:0] d);
      @(negedge wclk); b_wen = 1'b1; b_wdata = d;
      @(negedge wclk); b_wen = 1'b0;
   endtask

   task automatic b_read();
      @(negedge rclk); b_ren = 1'b1;
      @(negedge rclk); b_ren = 1'b0;
   endtask

   task automatic settle();
      repeat (8) @(negedge wclk);
      repeat (8) @(negedge rclk);
   endtask

   task automatic summary();
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
   endtask

   initial begin
      wrst_n = 1'b0; rrst_n = 1'b0;
      a_wen = 1'b0; a_wdata = '0; a_ren = 1'b0;
      b_wen = 1'b0; b_wdata = '0; b_ren = 1'b0;

      // R1: reset behaviour
      repeat (3) @(negedge wclk);
      chk("R1", "full during reset", a_full, 1);
      a_write(32'hCAFEF00D);
      chk("R1", "no ack during reset", a_ack, 0);
      @(negedge wclk); wrst_n = 1'b1; rrst_n = 1'b1;
      settle();
      chk("R1", "full after reset", a_full, 0);
      chk("R1", "almost full after reset", a_afull, 0);
      chk("R1", "write level after reset", a_wlvl, 0);
      chk("R1", "empty after reset", a_empty, 1);
      chk("R1", "almost empty after reset", a_aempty, 1);
      chk("R1", "read level after reset", a_rlvl, 0);
      chk("R1", "packing side empty after reset", b_empty, 1);

      // R5: read while empty
      a_read();
      chk("R5", "underflow strobe", a_udf, 1);
      chk("R5", "no valid on underflow", a_valid, 0);
      chk("R5", "level unchanged", a_rlvl, 0);

      // R2, R6, R10: table walk
      for (int i = 0; i < 8; i++) begin
         a_write(VEC[i]);
         chk("R6", "write ack", a_ack, 1);
         chk("R7", "write level", a_wlvl, i + 1);
      end
      settle();
      chk("R8", "read level after table", a_rlvl, 32);
      chk("R8", "not empty", a_empty, 0);
      for (int k = 0; k < 32; k++) begin
         a_read();
         chk("R6", "read valid", a_valid, 1);
         chk("R2_R10", "split slice order", a_rdata, slice_of(VEC[k/4], k%4));
      end
      settle();
      chk("R8", "empty after table", a_empty, 1);
      chk("R7", "write level after table", a_wlvl, 0);

      // R7, R4: fill to the top
      for (int i = 0; i < 16; i++) begin
         a_write(fill_word(i));
         chk("R7", "fill level", a_wlvl, i + 1);
         chk("R7", "almost full", a_afull, (i + 1 >= 15) ? 1 : 0);
      end
      chk("R7", "full at depth", a_full, 1);
      a_write(32'h5EC0DE55);
      chk("R4", "overflow strobe", a_ovf, 1);
      chk("R4", "no ack when full", a_ack, 0);
      chk("R4", "level unchanged", a_wlvl, 16);
      settle();
      chk("R8", "read level full", a_rlvl, 64);
      chk("R8", "almost empty low", a_aempty, 0);
      for (int k = 0; k < 3; k++) begin
         a_read();
         chk("R2", "drain data", a_rdata, slice_of(fill_word(k/4), k%4));
      end
      settle();
      chk("R9", "full held until wide word drained", a_full, 1);
      a_read();
      chk("R2", "drain data", a_rdata, slice_of(fill_word(0), 3));
      settle();
      chk("R9", "full released", a_full, 0);
      chk("R7", "level after one wide word", a_wlvl, 15);
      chk("R7", "almost full at depth-1", a_afull, 1);
      for (int k = 4; k < 64; k++) begin
         a_read();
         chk("R4", "stored data untouched", a_rdata, slice_of(fill_word(k/4), k%4));
         chk("R8", "read level", a_rlvl, 63 - k);
         chk("R8", "almost empty", a_aempty, (63 - k <= 1) ? 1 : 0);
      end
      chk("R8", "empty after drain", a_empty, 1);
      a_read();
      chk("R5", "underflow after drain", a_udf, 1);
      chk("R5", "no valid after drain", a_valid, 0);
      settle();
      chk("R7", "write level drained", a_wlvl, 0);

      // R3: narrow-to-wide packing
      for (int i = 0; i < 6; i++) begin
         b_write(8'h11 + 8'(i));
         chk("R6", "packing ack", b_ack, 1);
         chk("R7", "packing write level", b_wlvl, i + 1);
      end
      settle();
      chk("R8", "whole words only", b_rlvl, 1);
      chk("R8", "packing not empty", b_empty, 0);
      b_read();
      chk("R6", "packing valid", b_valid, 1);
      chk("R3", "first narrow word in top slice", b_rdata, 32'h11121314);
      chk("R8", "partial word not readable", b_empty, 1);
      settle();
      chk("R7", "packing write level left", b_wlvl, 2);

      summary();
      done = 1'b1;
      $finish;
   end

   initial begin
      #1_000_000;
      if (!done) begin
         n_run++;
         n_fail++;
         $display("FAIL R10 watchdog: actual timeout expected completion");
         summary();
         $finish;
      end
   end

endmodule